// File: doc/BRIEF.md
# Frequency Select and Micro-Step Controller

This block decides which of 32 predefined synthesiser operating points is active and how far the CPU clock is trimmed away from it. The operating point comes either from board strap pins, captured once when power-up completes, or from a frequency field in control byte 0. A fine trim, kept in control byte 7 as a signed step count, moves the CPU clock in steps of 0.22 MHz around the chosen table entry. The block reports the CPU frequency that results, in hundredths of a MHz. The other bus clocks follow the CPU clock in the same proportion, so this one figure describes the whole clock tree.

A recovery watchdog, which lives outside this block, can take control of the selection. It can make the block use a fall-back operating point taken from byte 6. It can also make the block go back to the strapped point. Either override stays in force until software writes a new value to byte 0.

All results leave the block through one register stage, so the index, the trim value, the frequency and the spread flag always change on the same edge. A one-cycle strobe marks that edge. The outputs are plain levels and carry no flow control: the synthesiser is expected to sample them whenever the strobe is high.

Top module: `freq_select_ctrl`

## Requirements
- R1: While reset is asserted, and after it until anything changes, the outputs read as follows: index 31, trim 0, frequency 13330, spread flag 1, strobe 0 and stop-pin-is-input 0. These are the values that undriven pull-up straps give.
- R2: The 5-bit strap index (bit 4 = FS4 down to bit 0 = FS0) and the mode strap are captured on the first power-up-done pulse. Later strap changes and later pulses have no effect.
- R3: A mode strap captured low sets stop_pin_is_input to 1. A mode strap captured high leaves it at 0.
- R4: With no override active, byte 0 bit 3 = 1 selects the index {byte0[2], byte0[7:4]}, with byte0[2] as the MSB. Byte 0 bit 3 = 0 selects the captured strap index.
- R5: Byte 7 is a sign-magnitude trim: bit 7 = 1 means negative and bits 6..0 are the magnitude. The trim_m output is its two's-complement value, and negative zero gives 0.
- R6: freq_x100 = table[index] + 22 × trim. Example table entries: 3 → 6680, 13 → 15000, 15 → 13330, 22 → 13650, 29 → 15500.
- R7: down_spread is 1 exactly for indices 23, 24 and 31.
- R8: The outputs update one clock after the selecting inputs change. freq_change is high for exactly that one cycle, and only if the index or the trim actually changed.
- R9: A fall-back command captures fb_index (byte 6 bits 7..3) and uses it as the index, whatever byte 0 bit 3 holds. The override ends when byte 0 changes value.
- R10: A revert command forces the strap index until byte 0 changes value. It takes priority over a fall-back command in the same cycle.
- R11: The trim applies under every index source, overrides included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| strap_idx | input | 5 | Frequency strap pins, FS4..FS0 |
| strap_mode | input | 1 | Mode strap pin |
| pwrup_done | input | 1 | Power-up complete pulse |
| reg0 | input | 8 | Control byte 0 |
| reg7 | input | 8 | Control byte 7, sign-magnitude trim |
| fb_index | input | 5 | Byte 6 bits 7..3, fall-back index |
| wd_load_fb | input | 1 | Watchdog fall-back command |
| wd_revert | input | 1 | Watchdog revert-to-strap command |
| sel_index | output | 5 | Active table index |
| trim_m | output | 8 | Signed trim, two's complement |
| freq_x100 | output | 16 | CPU frequency in 0.01 MHz |
| down_spread | output | 1 | 1 = down spread, 0 = centre spread |
| freq_change | output | 1 | One-cycle update strobe |
| stop_pin_is_input | output | 1 | Shared pin acts as CPU-stop input |

## Verification
The override state and the captured strap value live inside the block, and neither can be read at the ports. The bench therefore shows them by choosing stimulus where a wrong state would put a different index or frequency on the outputs. A lost override, or a strap capture that fires a second time, shows up on sel_index and freq_x100 two clocks after the command or the pulse. A wrong trim decode shows up in freq_x100 one clock after byte 7 changes. A misplaced strobe is seen in the very cycle the outputs move.

// File: rtl/fsel_pkg.sv
`timescale 1ns/1ps
package fsel_pkg;
  localparam int IDX_W  = 5;
  localparam int TBL_W  = 16;

  typedef enum logic [1:0] {
    OVR_NONE     = 2'd0,
    OVR_FALLBACK = 2'd1,
    OVR_STRAP    = 2'd2
  } ovr_e;

  // Operating-point frequency in 0.01 MHz, index = {FS4,FS3,FS2,FS1,FS0}
  function automatic logic [TBL_W-1:0] op_freq(input logic [IDX_W-1:0] idx);
    logic [TBL_W-1:0] f;
    case (idx)
      5'd0:  f = 16'd12400;  5'd1:  f = 16'd7500;
      5'd2:  f = 16'd8330;   5'd3:  f = 16'd6680;
      5'd4:  f = 16'd10300;  5'd5:  f = 16'd11200;
      5'd6:  f = 16'd13330;  5'd7:  f = 16'd10000;
      5'd8:  f = 16'd12000;  5'd9:  f = 16'd11500;
      5'd10: f = 16'd11000;  5'd11: f = 16'd10500;
      5'd12: f = 16'd14000;  5'd13: f = 16'd15000;
      5'd14: f = 16'd12400;  5'd15: f = 16'd13330;
      5'd16: f = 16'd9000;   5'd17: f = 16'd9250;
      5'd18: f = 16'd9500;   5'd19: f = 16'd9750;
      5'd20: f = 16'd10150;  5'd21: f = 16'd12700;
      5'd22: f = 16'd13650;  5'd23: f = 16'd10000;
      5'd24: f = 16'd12000;  5'd25: f = 16'd11750;
      5'd26: f = 16'd12200;  5'd27: f = 16'd10750;
      5'd28: f = 16'd14500;  5'd29: f = 16'd15500;
      5'd30: f = 16'd13000;  default: f = 16'd13330;
    endcase
    return f;
  endfunction

  function automatic logic op_down_spread(input logic [IDX_W-1:0] idx);
    return (idx == 5'd23) || (idx == 5'd24) || (idx == 5'd31);
  endfunction
endpackage

// File: rtl/fsel_strap_latch.sv
`timescale 1ns/1ps
module fsel_strap_latch #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] strap_idx,
  input  logic             strap_mode,
  input  logic             pwrup_done,
  output logic [IDX_W-1:0] idx_q,
  output logic             stop_in_q
);
  logic done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q     <= '1;
      stop_in_q <= 1'b0;
      done_q    <= 1'b0;
    end else if (pwrup_done && !done_q) begin
      idx_q     <= strap_idx;
      stop_in_q <= ~strap_mode;
      done_q    <= 1'b1;
    end
  end

  assert_strap_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && $past(done_q)) |-> ($stable(idx_q) && $stable(stop_in_q)));
endmodule

// File: rtl/fsel_source_arb.sv
`timescale 1ns/1ps
module fsel_source_arb
  import fsel_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       reg0,
  input  logic [IDX_W-1:0] strap_q,
  input  logic [IDX_W-1:0] fb_index,
  input  logic             wd_load_fb,
  input  logic             wd_revert,
  output logic [IDX_W-1:0] eff_idx
);
  ovr_e             ovr_q;
  logic [IDX_W-1:0] fb_q;
  logic [7:0]       reg0_q;
  logic [IDX_W-1:0] reg_idx;

  assign reg_idx = {reg0[2], reg0[7:4]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q  <= OVR_NONE;
      fb_q   <= '0;
      reg0_q <= '0;
    end else begin
      reg0_q <= reg0;
      if (wd_revert) begin
        ovr_q <= OVR_STRAP;
      end else if (wd_load_fb) begin
        ovr_q <= OVR_FALLBACK;
        fb_q  <= fb_index;
      end else if (reg0 != reg0_q) begin
        ovr_q <= OVR_NONE;
      end
    end
  end

  always_comb begin
    case (ovr_q)
      OVR_STRAP:    eff_idx = strap_q;
      OVR_FALLBACK: eff_idx = fb_q;
      default:      eff_idx = reg0[3] ? reg_idx : strap_q;
    endcase
  end

  assert_fallback_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_load_fb && !wd_revert) |=> (ovr_q == OVR_FALLBACK && fb_q == $past(fb_index)));
  assert_revert_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wd_revert |=> (ovr_q == OVR_STRAP));
endmodule

// File: rtl/fsel_freq_calc.sv
`timescale 1ns/1ps
module fsel_freq_calc
  import fsel_pkg::*;
#(
  parameter int IDX_W     = 5,
  parameter int M_W       = 8,
  parameter int FREQ_W    = 16,
  parameter int STEP_X100 = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  eff_idx,
  input  logic [M_W-1:0]    m_raw,
  output logic [IDX_W-1:0]  idx_q,
  output logic [M_W-1:0]    m_q,
  output logic [FREQ_W-1:0] freq_q,
  output logic              ds_q,
  output logic              chg_q
);
  localparam int MAG_MAX = (1 << (M_W-1)) - 1;
  localparam int F_MIN   = 6680 - MAG_MAX*STEP_X100;
  localparam int F_MAX   = 15500 + MAG_MAX*STEP_X100;

  logic [M_W-1:0]    m_next;
  logic [M_W-1:0]    mag;
  logic [FREQ_W-1:0] f_next;
  int                f_sum;

  assign mag = {1'b0, m_raw[M_W-2:0]};

  always_comb begin
    m_next = m_raw[M_W-1] ? (~mag + 1'b1) : mag;
    f_sum  = int'(op_freq(eff_idx)) + int'($signed(m_next)) * STEP_X100;
    f_next = f_sum[FREQ_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '1;
      m_q    <= '0;
      freq_q <= FREQ_W'(13330);
      ds_q   <= 1'b1;
      chg_q  <= 1'b0;
    end else begin
      idx_q  <= eff_idx;
      m_q    <= m_next;
      freq_q <= f_next;
      ds_q   <= op_down_spread(eff_idx);
      chg_q  <= (eff_idx != idx_q) || (m_next != m_q);
    end
  end

  assert_strobe_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chg_q |-> (idx_q != $past(idx_q) || m_q != $past(m_q)));
  assert_quiet_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !chg_q |-> ($stable(idx_q) && $stable(m_q) && $stable(freq_q)));
  assert_freq_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(freq_q) >= F_MIN && int'(freq_q) <= F_MAX));
  assert_spread_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ds_q |-> (idx_q == 5'd23 || idx_q == 5'd24 || idx_q == 5'd31));
endmodule

// File: rtl/freq_select_ctrl.sv
`timescale 1ns/1ps
module freq_select_ctrl
  import fsel_pkg::*;
#(
  parameter int M_W       = 8,
  parameter int FREQ_W    = 16,
  parameter int STEP_X100 = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  strap_idx,
  input  logic              strap_mode,
  input  logic              pwrup_done,
  input  logic [7:0]        reg0,
  input  logic [M_W-1:0]    reg7,
  input  logic [IDX_W-1:0]  fb_index,
  input  logic              wd_load_fb,
  input  logic              wd_revert,
  output logic [IDX_W-1:0]  sel_index,
  output logic [M_W-1:0]    trim_m,
  output logic [FREQ_W-1:0] freq_x100,
  output logic              down_spread,
  output logic              freq_change,
  output logic              stop_pin_is_input
);
  logic [IDX_W-1:0] strap_q;
  logic [IDX_W-1:0] eff_idx;

  fsel_strap_latch #(.IDX_W(IDX_W)) u_strap (
    .clk(clk), .rst_n(rst_n), .strap_idx(strap_idx), .strap_mode(strap_mode),
    .pwrup_done(pwrup_done), .idx_q(strap_q), .stop_in_q(stop_pin_is_input)
  );

  fsel_source_arb #(.IDX_W(IDX_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .reg0(reg0), .strap_q(strap_q),
    .fb_index(fb_index), .wd_load_fb(wd_load_fb), .wd_revert(wd_revert),
    .eff_idx(eff_idx)
  );

  fsel_freq_calc #(.IDX_W(IDX_W), .M_W(M_W), .FREQ_W(FREQ_W), .STEP_X100(STEP_X100)) u_calc (
    .clk(clk), .rst_n(rst_n), .eff_idx(eff_idx), .m_raw(reg7),
    .idx_q(sel_index), .m_q(trim_m), .freq_q(freq_x100),
    .ds_q(down_spread), .chg_q(freq_change)
  );

  assert_reset_outputs_R1: assert property (@(posedge clk)
    !rst_n |=> (!rst_n ? (sel_index == '1 && trim_m == '0 && !freq_change) : 1'b1));
endmodule

// File: tb/freq_select_ctrl_test.sv
`timescale 1ns/1ps
module freq_select_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  strap_idx = 5'b11111;
  logic        strap_mode = 1'b1;
  logic        pwrup_done = 1'b0;
  logic [7:0]  reg0 = 8'h00;
  logic [7:0]  reg7 = 8'h00;
  logic [4:0]  fb_index = 5'd0;
  logic        wd_load_fb = 1'b0;
  logic        wd_revert = 1'b0;
  logic [4:0]  sel_index;
  logic [7:0]  trim_m;
  logic [15:0] freq_x100;
  logic        down_spread, freq_change, stop_pin_is_input;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  freq_select_ctrl uut (
    .clk(clk), .rst_n(rst_n), .strap_idx(strap_idx), .strap_mode(strap_mode),
    .pwrup_done(pwrup_done), .reg0(reg0), .reg7(reg7), .fb_index(fb_index),
    .wd_load_fb(wd_load_fb), .wd_revert(wd_revert), .sel_index(sel_index),
    .trim_m(trim_m), .freq_x100(freq_x100), .down_spread(down_spread),
    .freq_change(freq_change), .stop_pin_is_input(stop_pin_is_input)
  );

  typedef struct packed {
    logic [7:0]  r0;
    logic [7:0]  r7;
    logic [4:0]  idx;
    logic [7:0]  m;
    logic [15:0] f;
    logic        ds;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{8'h00, 8'h00, 5'd3,  8'h00, 16'd6680,  1'b0},
    '{8'h6C, 8'h0B, 5'd22, 8'h0B, 16'd13892, 1'b0},
    '{8'h7C, 8'h85, 5'd23, 8'hFB, 16'd9890,  1'b1},
    '{8'hF8, 8'hFF, 5'd15, 8'h81, 16'd10536, 1'b0},
    '{8'hFC, 8'h7F, 5'd31, 8'h7F, 16'd16124, 1'b1},
    '{8'hD8, 8'h80, 5'd13, 8'h00, 16'd15000, 1'b0},
    '{8'h8C, 8'h01, 5'd24, 8'h01, 16'd12022, 1'b1},
    '{8'h38, 8'hFF, 5'd3,  8'h81, 16'd3886,  1'b0},
    '{8'h54, 8'h00, 5'd3,  8'h00, 16'd6680,  1'b0},
    '{8'hD4, 8'h14, 5'd3,  8'h14, 16'd7120,  1'b0},
    '{8'hDC, 8'h00, 5'd29, 8'h00, 16'd15500, 1'b0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic outs(input string req, input int idx, input int f);
    chk(req, "sel_index", int'(sel_index), idx);
    chk(req, "freq_x100", int'(freq_x100), f);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R1 reset state
    outs("R1", 31, 13330);
    chk("R1", "trim_m", int'(trim_m), 0);
    chk("R1", "down_spread", int'(down_spread), 1);
    chk("R1", "freq_change", int'(freq_change), 0);
    chk("R1", "stop_pin_is_input", int'(stop_pin_is_input), 0);

    // R2/R3 strap capture
    strap_idx = 5'b00011; strap_mode = 1'b0;
    pwrup_done = 1'b1; @(negedge clk); pwrup_done = 1'b0;
    settle();
    outs("R2", 3, 6680);
    chk("R3", "stop_pin_is_input", int'(stop_pin_is_input), 1);
    strap_idx = 5'b11000; strap_mode = 1'b1;
    pwrup_done = 1'b1; @(negedge clk); pwrup_done = 1'b0;
    settle();
    outs("R2", 3, 6680);
    chk("R2", "stop_pin_is_input", int'(stop_pin_is_input), 1);

    // R4..R7 vector walk
    for (int i = 0; i < NV; i++) begin
      reg0 = VEC[i].r0; reg7 = VEC[i].r7;
      settle();
      chk("R4", "sel_index", int'(sel_index), int'(VEC[i].idx));
      chk("R5", "trim_m", int'(trim_m), int'(VEC[i].m));
      chk("R6", "freq_x100", int'(freq_x100), int'(VEC[i].f));
      chk("R7", "down_spread", int'(down_spread), int'(VEC[i].ds));
    end

    // R8 strobe timing
    reg0 = 8'h00; reg7 = 8'h00;
    settle();
    reg7 = 8'h02;
    @(posedge clk); @(negedge clk);
    chk("R8", "freq_change first cycle", int'(freq_change), 1);
    chk("R8", "trim_m same cycle", int'(trim_m), 2);
    chk("R8", "freq_x100 same cycle", int'(freq_x100), 6724);
    @(negedge clk);
    chk("R8", "freq_change second cycle", int'(freq_change), 0);
    reg0 = 8'h38;  // register source, same index 3
    @(posedge clk); @(negedge clk);
    chk("R8", "freq_change same index", int'(freq_change), 0);
    reg7 = 8'h00;
    settle();

    // R9 fall-back override
    reg0 = 8'hF8;
    settle();
    outs("R9", 15, 13330);
    fb_index = 5'b10111;
    wd_load_fb = 1'b1; @(negedge clk); wd_load_fb = 1'b0;
    settle();
    outs("R9", 23, 10000);
    chk("R9", "down_spread", int'(down_spread), 1);
    fb_index = 5'd0;
    settle();
    outs("R9", 23, 10000);
    reg0 = 8'h58;
    settle();
    outs("R9", 5, 11200);

    // R10 revert, R11 trim under override
    wd_revert = 1'b1; @(negedge clk); wd_revert = 1'b0;
    settle();
    outs("R10", 3, 6680);
    reg7 = 8'h0A;
    settle();
    outs("R11", 3, 6900);
    reg0 = 8'h68;
    settle();
    outs("R10", 6, 13550);
    fb_index = 5'b11101;
    wd_revert = 1'b1; wd_load_fb = 1'b1; @(negedge clk);
    wd_revert = 1'b0; wd_load_fb = 1'b0;
    settle();
    outs("R10", 3, 6900);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule